// File: doc/BRIEF.md
# Serial Register Transfer Engine

This block lets software run single register reads and writes on an external converter over a four-wire serial bus. Software uses a small word-addressed register interface. It loads the outgoing data, picks an 8-bit or 16-bit data phase with a size flag, places the 8-bit target address in the top byte of the control word, and then raises the start bit. The engine shifts out the address and then the data, most significant bit first, with chip-select held low for the whole frame. A status bit stays high while a frame is active.

A read is an ordinary frame whose address has its top bit set. During the data phase the engine samples the serial input on each rising serial clock. It places the result right-justified in a read-only readback word. A stream option repeats the data phase after one address phase for as long as the start bit stays high. A synchronized option holds the frame until an external trigger pulse arrives. Software clears the start bit itself, and only a rising edge of that bit launches a new frame.

Top module: `xfer_engine`

## Requirements
- R1: After reset, chip-select is high, the serial clock and serial output are low, and the status and readback words read as zero.
- R2: Status bit 4 (offset 0xC) reads 1 from the clock cycle after the start bit (control bit 0, offset 0x0) is first seen high. It returns to 0 once the frame ends with chip-select high.
- R3: A frame starts only on a 0-to-1 change of the start bit. A start bit left high after a frame has finished launches nothing.
- R4: A frame sends the 8 address bits (control bits 31:24) MSB first and then the data bits MSB first. Chip-select is low throughout, and the serial output is stable while the serial clock is high.
- R5: With the size flag (bit 0 of offset 0x8) clear, the data phase is 16 bits, taken from bits 23:8 of the write-data word (offset 0x4).
- R6: With the size flag set, the data phase is 8 bits, taken from bits 23:16 of the write-data word.
- R7: When address bit 7 is set, the data-phase bits sampled from the serial input on rising serial clocks are stored right-justified in the readback word (offset 0x10, upper bits zero). Frames with address bit 7 clear leave the readback word unchanged.
- R8: When control bits 1 and 0 are both set, a single address phase is followed by repeated data phases. When the start bit is cleared, the data phase in progress completes and the frame ends.
- R9: When control bit 2 is set, a launched frame waits with status busy and chip-select high until the trigger input is high for a cycle.
- R10: The control word reads back bits 31:24 and 7:0 as written. The write-data word reads back bits 23:8, the size word reads back bit 0, and all other bits read as zero.
- R11: Each serial clock level lasts HALF_DIV system clock cycles within a phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte address (word aligned) |
| bus_wdata | input | BUS_W | Register write data |
| bus_rdata | output | BUS_W | Register read data (combinational) |
| sync_trig | input | 1 | Trigger that releases a synchronized frame |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
Two events can coincide. In stream mode, software may clear the start bit while a data word is still being shifted. The end-of-word decision then falls in the same cycle as the last falling serial clock edge, and it must take the cleared bit. The bench clears the bit in the middle of the third word. It then checks that exactly three words and one address byte were clocked out. A second collision arises when the start bit stays high as the frame ends, so the done condition and a still-high start bit meet. The bench counts serial clocks for a long idle window and checks that no second frame begins.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int CTRL_GO_BIT     = 0;
  localparam int CTRL_STREAM_BIT = 1;
  localparam int CTRL_SYNC_BIT   = 2;
  localparam int CTRL_ADDR_LSB   = 24;
  localparam int STAT_BUSY_BIT   = 4;
  localparam int WDATA_LSB       = 8;
  localparam int SYM_W           = 8;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_WDATA = 1;
  localparam int OFS_FMT   = 2;
  localparam int OFS_STAT  = 3;
  localparam int OFS_RBACK = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SYNC,
    ST_ALOAD,
    ST_ASHIFT,
    ST_DLOAD,
    ST_DSHIFT,
    ST_END
  } seq_state_t;
endpackage

// File: rtl/xfer_regs.sv
module xfer_regs
  import xfer_pkg::*;
#(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 5,
  parameter int TA_W   = 8,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              busy,
  input  logic              rb_we,
  input  logic [DW-1:0]     rb_din,
  output logic [TA_W-1:0]   tgt_addr,
  output logic              go,
  output logic              stream,
  output logic              sync_req,
  output logic              sym8,
  output logic [DW-1:0]     wdata
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int LOW_W  = 8;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              ctrl_en, wd_en, fmt_en;
  logic [TA_W-1:0]   addr_q;
  logic [LOW_W-1:0]  low_q;
  logic [DW-1:0]     wd_q;
  logic              fmt_q;
  logic [DW-1:0]     rb_q;

  assign word    = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign ctrl_en = bus_we && aligned && (word == WORD_W'(OFS_CTRL));
  assign wd_en   = bus_we && aligned && (word == WORD_W'(OFS_WDATA));
  assign fmt_en  = bus_we && aligned && (word == WORD_W'(OFS_FMT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      low_q  <= '0;
    end else if (ctrl_en) begin
      addr_q <= bus_wdata[CTRL_ADDR_LSB +: TA_W];
      low_q  <= bus_wdata[LOW_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wd_q <= '0;
    else if (wd_en) wd_q <= bus_wdata[WDATA_LSB +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fmt_q <= 1'b0;
    else if (fmt_en) fmt_q <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_q <= '0;
    else if (rb_we) rb_q <= rb_din;
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (word)
        WORD_W'(OFS_CTRL): begin
          bus_rdata[CTRL_ADDR_LSB +: TA_W] = addr_q;
          bus_rdata[LOW_W-1:0]            = low_q;
        end
        WORD_W'(OFS_WDATA): bus_rdata[WDATA_LSB +: DW] = wd_q;
        WORD_W'(OFS_FMT):   bus_rdata[0] = fmt_q;
        WORD_W'(OFS_STAT):  bus_rdata[STAT_BUSY_BIT] = busy;
        WORD_W'(OFS_RBACK): bus_rdata[DW-1:0] = rb_q;
        default:            bus_rdata = '0;
      endcase
    end
  end

  assign tgt_addr = addr_q;
  assign go       = low_q[CTRL_GO_BIT];
  assign stream   = low_q[CTRL_STREAM_BIT];
  assign sync_req = low_q[CTRL_SYNC_BIT];
  assign sym8     = fmt_q;
  assign wdata    = wd_q;
endmodule

// File: rtl/xfer_shift.sv
module xfer_shift #(
  parameter int DW       = 16,
  parameter int CNT_W    = 5,
  parameter int HALF_DIV = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DW-1:0]    load_word,
  input  logic [CNT_W-1:0] load_bits,
  input  logic             miso,
  output logic             sclk,
  output logic             mosi,
  output logic             done,
  output logic [DW-1:0]    rx
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic             active_q, active_d;
  logic             sclk_q, sclk_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] left_q, left_d;
  logic [DW-1:0]    sr_q, sr_d;
  logic [DW-1:0]    rx_q, rx_d;
  logic             done_q, done_d;
  logic             tick;

  assign tick = (div_q == DIV_W'(HALF_DIV - 1));

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    div_d    = div_q;
    left_d   = left_q;
    sr_d     = sr_q;
    rx_d     = rx_q;
    done_d   = 1'b0;
    if (load) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      div_d    = '0;
      left_d   = load_bits;
      sr_d     = load_word;
    end else if (active_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[DW-2:0], miso};
        end else begin
          sclk_d = 1'b0;
          sr_d   = {sr_q[DW-2:0], 1'b0};
          left_d = left_q - CNT_W'(1);
          if (left_q == CNT_W'(1)) begin
            active_d = 1'b0;
            done_d   = 1'b1;
          end
        end
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      left_q   <= '0;
      sr_q     <= '0;
      rx_q     <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      div_q    <= div_d;
      left_q   <= left_d;
      sr_q     <= sr_d;
      rx_q     <= rx_d;
      done_q   <= done_d;
    end
  end

  assign sclk = sclk_q;
  assign mosi = active_q ? sr_q[DW-1] : 1'b0;
  assign done = done_q;
  assign rx   = rx_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int TA_W  = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             stream,
  input  logic             sync_req,
  input  logic             sync_trig,
  input  logic             sym8,
  input  logic [TA_W-1:0]  tgt_addr,
  input  logic [DW-1:0]    wdata,
  input  logic             sh_done,
  input  logic [DW-1:0]    sh_rx,
  output logic             busy,
  output logic             cs_n,
  output logic             sh_load,
  output logic [DW-1:0]    sh_word,
  output logic [CNT_W-1:0] sh_bits,
  output logic             rb_we,
  output logic [DW-1:0]    rb_din
);
  seq_state_t      state_q, state_d;
  logic            go_q;
  logic            launch;
  logic [TA_W-1:0] fr_addr_q;
  logic            fr_sym8_q;
  logic            cs_n_q, cs_n_d;

  assign launch = go && !go_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (launch) state_d = sync_req ? ST_SYNC : ST_ALOAD;
      ST_SYNC:   if (sync_trig) state_d = ST_ALOAD;
      ST_ALOAD:  state_d = ST_ASHIFT;
      ST_ASHIFT: if (sh_done) state_d = ST_DLOAD;
      ST_DLOAD:  state_d = ST_DSHIFT;
      ST_DSHIFT: if (sh_done) state_d = (stream && go) ? ST_DLOAD : ST_END;
      ST_END:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cs_n_d = !((state_d == ST_ALOAD) || (state_d == ST_ASHIFT) ||
               (state_d == ST_DLOAD) || (state_d == ST_DSHIFT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      go_q    <= go;
      cs_n_q  <= cs_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_addr_q <= '0;
      fr_sym8_q <= 1'b0;
    end else if ((state_q == ST_IDLE) && launch) begin
      fr_addr_q <= tgt_addr;
      fr_sym8_q <= sym8;
    end
  end

  always_comb begin
    sh_load = (state_q == ST_ALOAD) || (state_q == ST_DLOAD);
    if (state_q == ST_ALOAD) begin
      sh_word = {fr_addr_q, {(DW-TA_W){1'b0}}};
      sh_bits = CNT_W'(TA_W);
    end else if (fr_sym8_q) begin
      sh_word = {wdata[DW-1 -: SYM_W], {(DW-SYM_W){1'b0}}};
      sh_bits = CNT_W'(SYM_W);
    end else begin
      sh_word = wdata;
      sh_bits = CNT_W'(DW);
    end
  end

  assign rb_we  = (state_q == ST_DSHIFT) && sh_done && fr_addr_q[TA_W-1];
  assign rb_din = fr_sym8_q ? {{(DW-SYM_W){1'b0}}, sh_rx[SYM_W-1:0]} : sh_rx;
  assign busy   = (state_q != ST_IDLE);
  assign cs_n   = cs_n_q;
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine #(
  parameter int BUS_W    = 32,
  parameter int ADDR_W   = 5,
  parameter int TA_W     = 8,
  parameter int DW       = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              sync_trig,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int CNT_W = $clog2(DW + 1);

  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  logic             busy;
  logic             rb_we;
  logic [DW-1:0]    rb_din;
  logic [TA_W-1:0]  tgt_addr;
  logic             ctrl_go, ctrl_stream, ctrl_sync, sym8;
  logic [DW-1:0]    wdata;
  logic             sh_load, sh_done;
  logic [DW-1:0]    sh_word, sh_rx;
  logic [CNT_W-1:0] sh_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  xfer_regs #(.BUS_W(BUS_W), .ADDR_W(ADDR_W), .TA_W(TA_W), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .busy(busy), .rb_we(rb_we), .rb_din(rb_din),
    .tgt_addr(tgt_addr), .go(ctrl_go), .stream(ctrl_stream), .sync_req(ctrl_sync),
    .sym8(sym8), .wdata(wdata)
  );

  xfer_seq #(.TA_W(TA_W), .DW(DW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n_sync),
    .go(ctrl_go), .stream(ctrl_stream), .sync_req(ctrl_sync), .sync_trig(sync_trig),
    .sym8(sym8), .tgt_addr(tgt_addr), .wdata(wdata),
    .sh_done(sh_done), .sh_rx(sh_rx),
    .busy(busy), .cs_n(spi_cs_n), .sh_load(sh_load), .sh_word(sh_word), .sh_bits(sh_bits),
    .rb_we(rb_we), .rb_din(rb_din)
  );

  xfer_shift #(.DW(DW), .CNT_W(CNT_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk(clk), .rst_n(rst_n_sync),
    .load(sh_load), .load_word(sh_word), .load_bits(sh_bits), .miso(spi_miso),
    .sclk(spi_sclk), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          go,
  input logic          cs_n,
  input logic          sclk,
  input logic          mosi,
  input logic          rb_we,
  input logic [DW-1:0] rb_din
);
  p_cs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n);

  p_busy_go_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(go));

  p_sclk_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_cs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> busy);

  p_rb_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |-> (busy && !cs_n));

  p_rb_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rb_we |-> !$isunknown(rb_din));
endmodule

bind xfer_engine xfer_engine_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n_sync), .busy(busy), .go(ctrl_go),
  .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
  .rb_we(rb_we), .rb_din(rb_din)
);

// File: tb/xfer_engine_test.sv
`timescale 1ns/1ps
module xfer_engine_test;
  localparam int HALF = 2;
  localparam logic [4:0] A_CTRL = 5'h00, A_WD = 5'h04, A_FMT = 5'h08,
                         A_STAT = 5'h0C, A_RB = 5'h10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sync_trig = 1'b0;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        miso_b;

  int          n_chk = 0;
  int          n_bad = 0;
  int          bitcnt = 0;
  logic [63:0] frame = '0;
  logic [15:0] sl_word = '0;
  int          sl_n = 16;
  int          gap_bad = 0, gap_seen = 0, cs_bad = 0;
  realtime     last_rise = 0.0;
  logic [15:0] last_rb = '0;

  always #4 clk = ~clk;

  xfer_engine #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_trig(sync_trig),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(miso_b)
  );

  always @* begin
    miso_b = 1'b0;
    if (bitcnt >= 8 && bitcnt < 8 + sl_n) miso_b = sl_word[sl_n - 1 - (bitcnt - 8)];
  end

  always @(posedge spi_sclk) begin
    if (bitcnt >= 1 && bitcnt < 8) begin
      gap_seen++;
      if (($realtime - last_rise) > (2.0 * HALF * 8.0 + 0.1) ||
          ($realtime - last_rise) < (2.0 * HALF * 8.0 - 0.1)) gap_bad++;
    end
    last_rise = $realtime;
    if (spi_cs_n) cs_bad++;
    frame = {frame[62:0], spi_mosi};
    bitcnt++;
  end

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle(input string req);
    logic [31:0] s;
    bit ok = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 3000; i++) begin
      bus_read(A_STAT, s);
      if (!s[4]) begin ok = 1'b1; break; end
    end
    if (!ok) chk(req, 64'd1, 64'd0);
  endtask

  task automatic run_xfer(input logic [7:0] a, input logic [15:0] d, input bit s8,
                          input logic [15:0] sw);
    int n;
    logic [31:0] r;
    logic [63:0] exp_fr, mask;
    n = s8 ? 8 : 16;
    sl_word = sw; sl_n = n;
    bus_write(A_FMT, {31'd0, s8});
    bus_write(A_WD, s8 ? {8'h00, d[7:0], 16'h0000} : {8'h00, d, 8'h00});
    bus_write(A_CTRL, {a, 24'h000000});
    bitcnt = 0; frame = '0;
    bus_write(A_CTRL, {a, 24'h000001});
    wait_idle("R2 frame end");
    bus_write(A_CTRL, {a, 24'h000000});
    chk(s8 ? "R6 clock count" : "R5 clock count", 64'(bitcnt), 64'(8 + n));
    mask   = (64'd1 << (8 + n)) - 64'd1;
    exp_fr = s8 ? {48'd0, a, d[7:0]} : {40'd0, a, d};
    chk(s8 ? "R6 R4 frame bits" : "R5 R4 frame bits", frame & mask, exp_fr);
    bus_read(A_RB, r);
    if (a[7]) last_rb = s8 ? {8'h00, sw[7:0]} : sw;
    chk("R7 readback", 64'(r), 64'(last_rb));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL R2 watchdog expired got=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    #1;
    chk("R1 cs_n", 64'(spi_cs_n), 64'd1);
    chk("R1 sclk", 64'(spi_sclk), 64'd0);
    chk("R1 mosi", 64'(spi_mosi), 64'd0);
    bus_read(A_STAT, r); chk("R1 status", 64'(r), 64'd0);
    bus_read(A_RB, r);   chk("R1 readback", 64'(r), 64'd0);

    // R10 register readback
    bus_write(A_CTRL, 32'hAB0000FA);
    bus_read(A_CTRL, r); chk("R10 ctrl", 64'(r), 64'hAB0000FA);
    bus_write(A_CTRL, 32'h0);
    bus_write(A_WD, 32'hFFFFFFFF);
    bus_read(A_WD, r);   chk("R10 wdata", 64'(r), 64'h00FFFF00);
    bus_write(A_FMT, 32'hFFFFFFFF);
    bus_read(A_FMT, r);  chk("R10 fmt", 64'(r), 64'd1);
    chk("R10 no launch without start", 64'(bitcnt), 64'd0);

    // R2 busy timing
    bus_write(A_FMT, 32'd0);
    bus_write(A_CTRL, 32'h05000000);
    bitcnt = 0;
    bus_write(A_CTRL, 32'h05000001);
    bus_read(A_STAT, r); chk("R2 busy not before", 64'(r[4]), 64'd0);
    bus_read(A_STAT, r); chk("R2 busy next cycle", 64'(r[4]), 64'd1);
    wait_idle("R2 idle");
    chk("R2 cs_n high at end", 64'(spi_cs_n), 64'd1);

    // R3 start held high launches nothing
    bitcnt = 0;
    repeat (80) @(posedge clk);
    bus_read(A_STAT, r);
    chk("R3 no relaunch busy", 64'(r[4]), 64'd0);
    chk("R3 no relaunch clocks", 64'(bitcnt), 64'd0);
    bus_write(A_CTRL, 32'h05000000);

    // Sweep over all target addresses: writes and reads, both sizes
    for (int a = 0; a < 256; a++) begin
      run_xfer(8'(a), 16'((a * 37 + 11) ^ (a << 9)), a[0], 16'((a * 257) ^ 16'h5A3C));
    end
    run_xfer(8'h7F, 16'hFFFF, 1'b0, 16'h0000);
    run_xfer(8'h00, 16'h8001, 1'b0, 16'h0000);
    run_xfer(8'hFF, 16'h0000, 1'b0, 16'hFFFF);

    // R8 stream: stop in the middle of the third word
    sl_word = '0; sl_n = 16;
    bus_write(A_FMT, 32'd0);
    bus_write(A_WD, 32'h00123400);
    bus_write(A_CTRL, 32'h22000000);
    bitcnt = 0; frame = '0;
    bus_write(A_CTRL, 32'h22000003);
    for (int i = 0; i < 5000 && bitcnt < 41; i++) @(posedge clk);
    bus_write(A_CTRL, 32'h22000002);
    wait_idle("R8 stream end");
    chk("R8 stream clocks", 64'(bitcnt), 64'd56);
    chk("R8 stream addr", 64'(frame[55:48]), 64'h22);
    chk("R8 stream words", {16'd0, frame[47:0]}, 64'h0000_1234_1234_1234);
    bus_write(A_CTRL, 32'h0);

    // R9 synchronized frame
    bus_write(A_WD, 32'h00BEEF00);
    bus_write(A_CTRL, 32'h10000000);
    bitcnt = 0; frame = '0;
    bus_write(A_CTRL, 32'h10000005);
    repeat (20) @(posedge clk);
    bus_read(A_STAT, r);
    chk("R9 busy while waiting", 64'(r[4]), 64'd1);
    chk("R9 cs_n while waiting", 64'(spi_cs_n), 64'd1);
    chk("R9 no clocks while waiting", 64'(bitcnt), 64'd0);
    @(negedge clk) sync_trig = 1'b1;
    @(negedge clk) sync_trig = 1'b0;
    wait_idle("R9 end");
    chk("R9 clocks", 64'(bitcnt), 64'd24);
    chk("R9 frame", {40'd0, frame[23:0]}, 64'h10BEEF);
    bus_write(A_CTRL, 32'h0);

    // R11 serial clock period, R4 chip-select during clocks
    chk("R11 sclk period", 64'(gap_bad == 0 && gap_seen > 0), 64'd1);
    chk("R4 cs_n low on every sclk", 64'(cs_bad), 64'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule